// File: doc/BRIEF.md
# Minute-Resolution Watchdog Timer

This block is a watchdog that counts down in whole minutes. A one-minute tick and a millisecond tick both come from an external prescaler chain. Software programs an 8-bit timeout. While the watchdog runs, each minute tick takes one count off. Reaching zero is an expiry. On expiry the block drives a fixed 250 ms active-low pulse and can also latch an event that reaches the system as either an SMI-style or an SCI-style active-low request.

Activity on the serial-port interrupt lines or the keyboard/mouse interrupt lines restarts the countdown from the programmed timeout. Each of these two groups has its own enable bit. Software can also restart the countdown through a register write. A timeout of zero keeps the watchdog idle. After an expiry the counter stays at zero until something reloads it, so each expiry produces exactly one pulse.

The countdown is held by a three-state controller. State IDLE means the timeout is zero. State RUN means the counter is counting. State EXPIRED means the counter has reached zero and waits for a reload. Its transitions are:
- IDLE->RUN: a nonzero timeout is written.
- RUN->RUN: a reload or a minute tick.
- RUN->EXPIRED: a minute tick arrives at count 1.
- EXPIRED->RUN: a reload or a nonzero timeout write.
- RUN->IDLE and EXPIRED->IDLE: a zero timeout is written.

Top module: `minute_wdt`

The register map uses `cfg_addr`:
- 0: timeout.
- 1: control. Bit 0 is the serial restart enable, bit 1 the keyboard/mouse restart enable, bit 2 the event enable, and bit 3 the event select (0 = SMI-style, 1 = SCI-style).
- 2: restart. A write with bit 0 set restarts the countdown. A read returns the current count.
- 3: status. Bit 0 is the sticky event flag.

## Requirements
- R1: After reset the count is 0, `wdo_n`, `smi_n` and `sci_n` are 1, and the status read at address 3 is 0.
- R2: Writing a nonzero value T to address 0 sets the count to T on the next cycle. Each later minute tick lowers the count by one. The T-th tick brings the count to 0 and drives `wdo_n` low on the following cycle.
- R3: While the timeout is 0, the count stays 0 and minute ticks produce no pulse. Writing 0 while running stops the countdown at 0.
- R4: When control bit 0 is set, a high level on any `ser_irq` line reloads the count with the timeout. When the bit is clear, the line has no effect on the count.
- R5: When control bit 1 is set, a high level on any `kbm_irq` line reloads the count with the timeout. When the bit is clear, the line has no effect on the count.
- R6: A write to address 2 with bit 0 set reloads the count with the timeout, including from the EXPIRED state.
- R7: `wdo_n` stays low for exactly 250 millisecond ticks after expiry, whatever the minute ticks do.
- R8: After expiry the count stays at 0 under further minute ticks, and no second pulse occurs until the watchdog is reloaded.
- R9: On expiry with control bit 2 set, status bit 0 is set. It stays set through writes of 0 to address 3 and clears when 1 is written to address 3 bit 0.
- R10: While the status is set, `smi_n` is low if control bit 3 is 0 and `sci_n` is low if it is 1. The two are never low together. With control bit 2 clear, an expiry leaves the status at 0.
- R11: A reload in the same cycle as a minute tick at count 1 wins: the count becomes the timeout and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| min_tick | input | 1 | One-cycle strobe once per minute |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| ser_irq | input | N_SER | Serial-port interrupt lines |
| kbm_irq | input | 2 | Keyboard and mouse interrupt lines |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `cfg_addr` (combinational) |
| wdo_n | output | 1 | Active-low expiry pulse |
| smi_n | output | 1 | Active-low SMI-style event request |
| sci_n | output | 1 | Active-low SCI-style event request |

## Verification
The hardest situation to reach is a reload and the final minute tick arriving in the same cycle at count 1. An error there would either lose the restart or produce a spurious pulse. The bench steps the count down to 1 with single ticks and then drives `min_tick` and an enabled interrupt line together in one cycle. The bench also sweeps every timeout from 1 to 6 plus 255, counting the exact tick that expires and the pulse width in millisecond ticks. It applies extra minute ticks while the counter is parked at zero.

// File: rtl/minute_wdt_pkg.sv
package minute_wdt_pkg;
    localparam int REG_W = 8;

    localparam logic [1:0] A_TIMEOUT = 2'd0;
    localparam logic [1:0] A_CTRL    = 2'd1;
    localparam logic [1:0] A_RESTART = 2'd2;
    localparam logic [1:0] A_STATUS  = 2'd3;

    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,
        WS_RUN     = 2'd1,
        WS_EXPIRED = 2'd2
    } wdt_state_e;

    typedef struct packed {
        logic evt_sci;
        logic evt_en;
        logic kbm_en;
        logic ser_en;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import minute_wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             expire,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] timeout,
    output wdt_ctrl_t        ctrl,
    output logic             load_req,
    output logic             sw_restart,
    output logic             evt_sts,
    output logic [REG_W-1:0] rd_data
);
    logic wr_tmo, wr_ctl, wr_sts;

    assign wr_tmo     = cfg_wr && (cfg_addr == A_TIMEOUT);
    assign wr_ctl     = cfg_wr && (cfg_addr == A_CTRL);
    assign wr_sts     = cfg_wr && (cfg_addr == A_STATUS);
    assign load_req   = wr_tmo;
    assign sw_restart = cfg_wr && (cfg_addr == A_RESTART) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout <= '0;
            ctrl    <= '0;
            evt_sts <= 1'b0;
        end else begin
            if (wr_tmo) timeout <= cfg_wdata[CNT_W-1:0];
            if (wr_ctl) ctrl <= wdt_ctrl_t'(cfg_wdata[3:0]);
            if (expire && ctrl.evt_en)      evt_sts <= 1'b1;
            else if (wr_sts && cfg_wdata[0]) evt_sts <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (cfg_addr)
            A_TIMEOUT: rd_data[CNT_W-1:0] = timeout;
            A_CTRL:    rd_data[3:0]       = ctrl;
            A_RESTART: rd_data[CNT_W-1:0] = count;
            A_STATUS:  rd_data[0]         = evt_sts;
        endcase
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import minute_wdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             restart,
    input  logic             min_tick,
    input  logic [CNT_W-1:0] timeout,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = count;
        if (load_req) begin
            state_d = (load_val == '0) ? WS_IDLE : WS_RUN;
            cnt_d   = load_val;
        end else begin
            unique case (state_q)
                WS_IDLE: begin
                    cnt_d = '0;
                end
                WS_RUN: begin
                    if (restart) begin
                        cnt_d = timeout;
                    end else if (min_tick) begin
                        cnt_d = count - ONE;
                        if (count == ONE) state_d = WS_EXPIRED;
                    end
                end
                WS_EXPIRED: begin
                    if (restart) begin
                        state_d = WS_RUN;
                        cnt_d   = timeout;
                    end
                end
                default: begin
                    state_d = WS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        expire = !load_req && !restart && min_tick
                 && (state_q == WS_RUN) && (count == ONE);
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_MS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic ms_tick,
    output logic out_n
);
    localparam int PW = $clog2(PULSE_MS + 1);
    localparam logic [PW-1:0] LEN = PW'(PULSE_MS);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                           left_q <= '0;
        else if (fire)                        left_q <= LEN;
        else if (ms_tick && left_q != '0)     left_q <= left_q - PW'(1);
    end

    assign out_n = (left_q == '0);
endmodule

// File: rtl/minute_wdt.sv
module minute_wdt
    import minute_wdt_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int PULSE_MS = 250,
    parameter int N_SER    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             min_tick,
    input  logic             ms_tick,
    input  logic [N_SER-1:0] ser_irq,
    input  logic [1:0]       kbm_irq,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       rd_data,
    output logic             wdo_n,
    output logic             smi_n,
    output logic             sci_n
);
    logic [CNT_W-1:0] timeout, count;
    wdt_ctrl_t        ctrl;
    logic             load_req, sw_restart, evt_sts, expire, restart;

    assign restart = sw_restart
                   || (ctrl.ser_en && (|ser_irq))
                   || (ctrl.kbm_en && (|kbm_irq));

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .expire(expire), .count(count),
        .timeout(timeout), .ctrl(ctrl), .load_req(load_req),
        .sw_restart(sw_restart), .evt_sts(evt_sts), .rd_data(rd_data)
    );

    wdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .load_req(load_req),
        .load_val(cfg_wdata[CNT_W-1:0]), .restart(restart),
        .min_tick(min_tick), .timeout(timeout), .count(count),
        .expire(expire)
    );

    wdt_pulse #(.PULSE_MS(PULSE_MS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(expire), .ms_tick(ms_tick),
        .out_n(wdo_n)
    );

    assign smi_n = !(evt_sts && !ctrl.evt_sci);
    assign sci_n = !(evt_sts &&  ctrl.evt_sci);
endmodule

// File: rtl/minute_wdt_chk.sv
module minute_wdt_chk #(
    parameter int CNT_W = 8,
    parameter int N_SER = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             min_tick,
    input logic [N_SER-1:0] ser_irq,
    input logic [1:0]       kbm_irq,
    input logic             cfg_wr,
    input logic [1:0]       cfg_addr,
    input logic [7:0]       cfg_wdata,
    input logic             wdo_n,
    input logic             smi_n,
    input logic             sci_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] timeout,
    input logic             evt_sts
);
    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !min_tick && !(|ser_irq) && !(|kbm_irq)) |=> $stable(count));

    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (min_tick && count > CNT_W'(1) && !cfg_wr && !(|ser_irq) && !(|kbm_irq))
        |=> (count == $past(count) - CNT_W'(1)));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout == '0) |-> (count == '0));

    p_pulse_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> (count == '0));

    p_sts_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sts && !(cfg_wr && cfg_addr == 2'd3 && cfg_wdata[0])) |=> evt_sts);

    p_one_request_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!smi_n && !sci_n));
endmodule

bind minute_wdt minute_wdt_chk #(.CNT_W(CNT_W), .N_SER(N_SER)) u_chk (
    .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .ser_irq(ser_irq),
    .kbm_irq(kbm_irq), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wdo_n(wdo_n), .smi_n(smi_n), .sci_n(sci_n),
    .count(count), .timeout(timeout), .evt_sts(evt_sts)
);

// File: tb/minute_wdt_bench.sv
module minute_wdt_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_tick = 1'b0, ms_tick = 1'b0;
    logic [1:0] ser_irq = '0, kbm_irq = '0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] rd_data;
    logic       wdo_n, smi_n, sci_n;

    int  n_run = 0, n_fail = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    minute_wdt u_minute_wdt (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .ms_tick(ms_tick),
        .ser_irq(ser_irq), .kbm_irq(kbm_irq), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_data(rd_data),
        .wdo_n(wdo_n), .smi_n(smi_n), .sci_n(sci_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cfg_addr = a; #1; d = rd_data;
    endtask

    task automatic tick_min();
        @(negedge clk); min_tick = 1'b1;
        @(negedge clk); min_tick = 1'b0;
    endtask

    task automatic tick_ms();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
    endtask

    task automatic pulse_irq(input bit kbm, input int line);
        @(negedge clk);
        if (kbm) kbm_irq[line] = 1'b1; else ser_irq[line] = 1'b1;
        @(negedge clk); ser_irq = '0; kbm_irq = '0;
    endtask

    function automatic int cnt_now();
        return int'(rd_data);
    endfunction

    task automatic get_cnt(output int c);
        logic [7:0] d;
        rd(2'd2, d); c = int'(d);
    endtask

    task automatic wait_pulse_end(input string req);
        int n = 0;
        while (!wdo_n && n < 400) begin tick_ms(); n++; end
        chk(n == 250, req, n, 250);
    endtask

    initial begin
        int c; logic [7:0] d;
        int tv[7] = '{1, 2, 3, 4, 5, 6, 255};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        get_cnt(c);  chk(c == 0, "R1 count", c, 0);
        chk(wdo_n && smi_n && sci_n, "R1 outputs", {wdo_n, smi_n, sci_n}, 7);
        rd(2'd3, d); chk(d == 0, "R1 status", d, 0);

        // R3 zero timeout keeps idle
        repeat (5) tick_min();
        get_cnt(c); chk(c == 0 && wdo_n, "R3 idle count", c, 0);

        // R2 / R7 / R8 sweep
        foreach (tv[i]) begin
            int t = tv[i];
            wr(2'd0, 8'(t));
            get_cnt(c); chk(c == t, "R2 load", c, t);
            for (int k = 1; k < t; k++) begin
                tick_min();
                get_cnt(c); chk(c == t - k && wdo_n, "R2 step", c, t - k);
            end
            tick_min();
            get_cnt(c); chk(c == 0 && !wdo_n, "R2 expiry", {c, wdo_n}, 0);
            repeat (3) tick_min();
            get_cnt(c); chk(c == 0, "R8 parked", c, 0);
            wait_pulse_end("R7 width");
            repeat (3) tick_min();
            chk(wdo_n == 1'b1, "R8 single pulse", wdo_n, 1);
        end

        // R6 restart from expired
        wr(2'd0, 8'd4); repeat (4) tick_min();
        wr(2'd2, 8'd1);
        get_cnt(c); chk(c == 4, "R6 restart expired", c, 4);
        wait_pulse_end("R7 width 2");
        tick_min(); wr(2'd2, 8'd1);
        get_cnt(c); chk(c == 4, "R6 restart running", c, 4);
        wr(2'd2, 8'd0);
        get_cnt(c); chk(c == 4, "R6 bit0 clear", c, 4);

        // R3 zero write while running
        tick_min(); wr(2'd0, 8'd0);
        get_cnt(c); chk(c == 0, "R3 stop", c, 0);
        repeat (6) tick_min();
        chk(wdo_n == 1'b1, "R3 no pulse", wdo_n, 1);

        // R4 serial reload
        wr(2'd1, 8'h01); wr(2'd0, 8'd5); repeat (2) tick_min();
        pulse_irq(0, 1);
        get_cnt(c); chk(c == 5, "R4 reload", c, 5);
        wr(2'd1, 8'h00); repeat (2) tick_min();
        pulse_irq(0, 0);
        get_cnt(c); chk(c == 3, "R4 disabled", c, 3);

        // R5 keyboard/mouse reload
        pulse_irq(1, 0);
        get_cnt(c); chk(c == 3, "R5 disabled", c, 3);
        wr(2'd1, 8'h02);
        pulse_irq(1, 1);
        get_cnt(c); chk(c == 5, "R5 reload", c, 5);
        pulse_irq(0, 0); tick_min();
        get_cnt(c); chk(c == 4, "R5 serial off", c, 4);

        // R11 reload wins over final tick
        wr(2'd1, 8'h01); wr(2'd0, 8'd3); repeat (2) tick_min();
        @(negedge clk); min_tick = 1'b1; ser_irq[0] = 1'b1;
        @(negedge clk); min_tick = 1'b0; ser_irq = '0;
        get_cnt(c); chk(c == 3 && wdo_n, "R11 reload wins", c, 3);

        // R9 / R10 events
        wr(2'd1, 8'h04); wr(2'd0, 8'd1); tick_min();
        chk(!smi_n && sci_n, "R10 smi", {smi_n, sci_n}, 1);
        rd(2'd3, d); chk(d == 1, "R9 set", d, 1);
        wr(2'd3, 8'h00); rd(2'd3, d); chk(d == 1, "R9 sticky", d, 1);
        wr(2'd3, 8'h01); rd(2'd3, d); chk(d == 0, "R9 clear", d, 0);
        chk(smi_n && sci_n, "R10 released", {smi_n, sci_n}, 3);
        wr(2'd1, 8'h0C); wr(2'd2, 8'd1); tick_min();
        chk(smi_n && !sci_n, "R10 sci", {smi_n, sci_n}, 2);
        wr(2'd3, 8'h01);
        wr(2'd1, 8'h00); wr(2'd2, 8'd1); tick_min();
        rd(2'd3, d); chk(d == 0 && smi_n && sci_n, "R10 disabled", d, 0);
        wait_pulse_end("R7 width 3");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule